// File: doc/BRIEF.md
# Multi-Lane Deskew Buffer with Programmable Release

This block is the lane-alignment stage of a multi-lane serial link receiver. The lanes arrive with different skews. Each lane stores its decoded octets in a private FIFO. Storing begins at that lane's start-of-alignment marker, which is the first octet after the run of comma characters ends. Octets that arrive before the marker are dropped.

The FIFOs are not emptied as soon as data arrives. A controller first waits until every enabled lane has seen its marker. It then waits for the next edge of the multiframe clock, and then a further programmable number of octet cycles (`rbd`). At that instant all lanes start popping together, so the output word carries every lane with zero skew.

Because release is tied to the multiframe clock and not to arrival time, latency is the same from one restart to the next. A lane that must write into its full FIFO raises a sticky overflow flag. The flag clears only on reset.

Top module: `deskew_release_buffer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `ovf_err` and `out_data` are all 0.
- R2: An enabled lane stores nothing until it sees `in_valid` and `in_start` high together. The marker octet is stored, and so is every valid octet after it. The first output word carries each enabled lane's marker octet.
- R3: An LMFC edge is used for release only if it comes at least one cycle after the last enabled lane's marker. An edge in the same cycle as that marker, or earlier, is ignored. Release happens once per reset.
- R4: Let E be the cycle of the qualifying edge, with `rbd` sampled in cycle E. The release cycle is E + `rbd`, and `out_valid` first goes high in cycle E + `rbd` + 1. An `rbd` of 0 releases in the edge cycle itself.
- R5: After release, every enabled lane pops one octet on each cycle in which all enabled lanes hold data. `out_valid` is high in the cycle after each pop. Output word n holds octet n (counted from the marker) of every enabled lane.
- R6: A lane whose `lane_en` bit is 0 never stores data. Release does not wait for its marker. Its byte of `out_data` (bits 8l+7..8l for lane l) reads 0.
- R7: Each lane FIFO holds F*K octets. A write into a full FIFO with no pop in the same cycle drops the octet and sets `ovf_err`. `ovf_err` then stays high until reset.
- R8: Take two runs with the same lane skews relative to the LMFC and the same `rbd`, each after a reset. The first `out_valid` appears at the same offset from the first marker in both runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low asynchronous link reset |
| lane_en | input | LANES | Per-lane enable |
| in_valid | input | LANES | Per-lane octet valid |
| in_start | input | LANES | Per-lane start-of-alignment marker |
| in_data | input | LANES*OCT_W | Lane octets; lane l at bits 8l+7..8l |
| lmfc_edge | input | 1 | One-cycle pulse at each multiframe clock edge |
| rbd | input | clog2(F*K) | Release delay in octet cycles after the edge |
| out_data | output | LANES*OCT_W | Aligned lane octets; same lane order as the input |
| out_valid | output | 1 | `out_data` holds an aligned word |
| ovf_err | output | 1 | Sticky overflow of any enabled lane FIFO |

## Verification
The assertions assume the following about the inputs:
- `lmfc_edge` is a single-cycle pulse with period F*K.
- `lane_en` does not change between resets.
- `rbd` is steady around the qualifying edge.
- A marker is only meaningful together with `in_valid`.

The stimulus meets these conditions:
- It generates the edge from a free-running cycle count.
- It sets the enables and `rbd` only while reset is held.
- It drives every lane with one valid octet per cycle.
- It places markers at chosen skews from a chosen phase of the multiframe, so that each case lands on a known edge.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

  typedef enum logic [1:0] {
    RS_WAIT  = 2'd0,
    RS_COUNT = 2'd1,
    RS_RUN   = 2'd2
  } rel_state_e;

  // Next pointer position in a ring of the given depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    if (p + 1 >= depth) return 0;
    return p + 1;
  endfunction

  // Occupancy after one cycle with the given write and read strobes.
  function automatic int unsigned occ_next(input int unsigned occ, input logic wr, input logic rd);
    int unsigned n;
    n = occ;
    if (wr && !rd) n = occ + 1;
    else if (rd && !wr && occ != 0) n = occ - 1;
    return n;
  endfunction

endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo
  import dsk_pkg::*;
#(
  parameter int OCT_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_en,
  input  logic [OCT_W-1:0] wr_data,
  output logic [OCT_W-1:0] rd_data,
  output logic             nonempty,
  output logic             ovf_hit
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OCT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;
  logic             full, do_wr, do_rd;

  assign nonempty = (occ != '0);
  assign full     = (occ == CNT_W'(DEPTH));
  assign do_rd    = rd_en && nonempty;
  assign do_wr    = wr_req && (!full || do_rd);
  assign ovf_hit  = wr_req && full && !do_rd;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_wr) wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      if (do_rd) rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      occ <= CNT_W'(occ_next(32'(occ), do_wr, do_rd));
    end
  end
endmodule

// File: rtl/dsk_lane.sv
module dsk_lane #(
  parameter int OCT_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_on,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [OCT_W-1:0] in_data,
  input  logic             rd_en,
  output logic             armed,
  output logic [OCT_W-1:0] rd_data,
  output logic             nonempty,
  output logic             ovf_hit
);
  logic armed_q, wr_req, marker_seen;

  assign marker_seen = lane_on && in_valid && in_start;
  assign wr_req      = lane_on && in_valid && (armed_q || in_start);
  assign armed       = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (marker_seen) armed_q <= 1'b1;
  end

  dsk_lane_fifo #(.OCT_W(OCT_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .rd_en    (rd_en),
    .wr_data  (in_data),
    .rd_data  (rd_data),
    .nonempty (nonempty),
    .ovf_hit  (ovf_hit)
  );
endmodule

// File: rtl/dsk_release_ctrl.sv
module dsk_release_ctrl
  import dsk_pkg::*;
#(
  parameter int RBD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             group_armed,
  input  logic             group_has_data,
  input  logic             lmfc_edge,
  input  logic [RBD_W-1:0] rbd,
  output logic             fire,
  output logic             waiting,
  output logic             running,
  output logic             rd_en
);
  rel_state_e       st;
  logic [RBD_W-1:0] cnt;
  logic             qual_edge;

  assign waiting   = (st == RS_WAIT);
  assign running   = (st == RS_RUN);
  assign qual_edge = waiting && group_armed && lmfc_edge;
  assign fire      = (qual_edge && rbd == '0) || (st == RS_COUNT && cnt == RBD_W'(1));
  assign rd_en     = (fire || running) && group_has_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RS_WAIT;
      cnt <= '0;
    end else begin
      case (st)
        RS_WAIT: if (qual_edge) begin
          cnt <= rbd;
          st  <= (rbd == '0) ? RS_RUN : RS_COUNT;
        end
        RS_COUNT: begin
          cnt <= cnt - RBD_W'(1);
          if (fire) st <= RS_RUN;
        end
        RS_RUN:  st <= RS_RUN;
        default: st <= RS_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/deskew_release_buffer.sv
module deskew_release_buffer #(
  parameter int LANES = 4,
  parameter int OCT_W = 8,
  parameter int F_OCT = 2,
  parameter int K_FRM = 4,
  localparam int MF_LEN = F_OCT * K_FRM,
  localparam int RBD_W  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
  localparam int DW     = LANES * OCT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] in_valid,
  input  logic [LANES-1:0] in_start,
  input  logic [DW-1:0]    in_data,
  input  logic             lmfc_edge,
  input  logic [RBD_W-1:0] rbd,
  output logic [DW-1:0]    out_data,
  output logic             out_valid,
  output logic             ovf_err
);
  logic [LANES-1:0] armed_v, nonempty_v, ovf_v, lane_rd;
  logic [OCT_W-1:0] rd_v [LANES];
  logic             group_armed, group_has_data;
  logic             fire, waiting, running, rd_en;

  // Disabled lanes count as ready and as holding data.
  assign group_armed    = (&(armed_v | ~lane_en)) && (|lane_en);
  assign group_has_data = &(nonempty_v | ~lane_en);
  assign lane_rd        = {LANES{rd_en}} & lane_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dsk_lane #(.OCT_W(OCT_W), .DEPTH(MF_LEN)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_on  (lane_en[l]),
      .in_valid (in_valid[l]),
      .in_start (in_start[l]),
      .in_data  (in_data[l*OCT_W +: OCT_W]),
      .rd_en    (lane_rd[l]),
      .armed    (armed_v[l]),
      .rd_data  (rd_v[l]),
      .nonempty (nonempty_v[l]),
      .ovf_hit  (ovf_v[l])
    );
  end

  dsk_release_ctrl #(.RBD_W(RBD_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .group_armed    (group_armed),
    .group_has_data (group_has_data),
    .lmfc_edge      (lmfc_edge),
    .rbd            (rbd),
    .fire           (fire),
    .waiting        (waiting),
    .running        (running),
    .rd_en          (rd_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      out_valid <= rd_en;
      ovf_err   <= ovf_err | (|(ovf_v & lane_en));
      if (rd_en) begin
        for (int l = 0; l < LANES; l++) begin
          out_data[l*OCT_W +: OCT_W] <= lane_en[l] ? rd_v[l] : '0;
        end
      end
    end
  end
endmodule

// File: rtl/dsk_checker.sv
module dsk_checker #(
  parameter int LANES = 4,
  parameter int OCT_W = 8,
  parameter int RBD_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [LANES-1:0]       lane_en,
  input logic                   lmfc_edge,
  input logic [RBD_W-1:0]       rbd,
  input logic                   group_armed,
  input logic                   waiting,
  input logic                   fire,
  input logic                   running,
  input logic                   rd_en,
  input logic [LANES-1:0]       ovf_v,
  input logic                   out_valid,
  input logic [LANES*OCT_W-1:0] out_data,
  input logic                   ovf_err
);
  a_r3_fire_needs_all_armed: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> group_armed);

  a_r3_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !fire);

  a_r4_rbd0_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && group_armed && lmfc_edge && rbd == '0) |-> fire);

  a_r4_no_read_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !fire) |-> !rd_en);

  a_r5_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r5_valid_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> out_valid);

  a_r5_no_valid_without_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !out_valid);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r7_ovf_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(|(ovf_v & lane_en)));

  for (genvar i = 0; i < LANES; i++) begin : g_off
    a_r6_off_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !lane_en[i] && $past(!lane_en[i])) |-> out_data[i*OCT_W +: OCT_W] == '0);
  end
endmodule

bind deskew_release_buffer dsk_checker #(.LANES(LANES), .OCT_W(OCT_W), .RBD_W(RBD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_en     (lane_en),
  .lmfc_edge   (lmfc_edge),
  .rbd         (rbd),
  .group_armed (group_armed),
  .waiting     (waiting),
  .fire        (fire),
  .running     (running),
  .rd_en       (rd_en),
  .ovf_v       (ovf_v),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .ovf_err     (ovf_err)
);

// File: tb/deskew_release_buffer_tb.sv
module deskew_release_buffer_tb;
  localparam int LANES = 4;
  localparam int OCT_W = 8;
  localparam int F_OCT = 2;
  localparam int K_FRM = 4;
  localparam int MF    = F_OCT * K_FRM;
  localparam int DEPTH = MF;
  localparam int RBD_W = $clog2(MF);
  localparam int DW    = LANES * OCT_W;
  localparam int WDOG  = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LANES-1:0] lane_en, in_valid, in_start;
  logic [DW-1:0]    in_data;
  logic             lmfc_edge;
  logic [RBD_W-1:0] rbd;
  logic [DW-1:0]    out_data;
  logic             out_valid, ovf_err;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign lmfc_edge = (cyc % MF) == 0;

  deskew_release_buffer #(.LANES(LANES), .OCT_W(OCT_W), .F_OCT(F_OCT), .K_FRM(K_FRM)) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .lmfc_edge(lmfc_edge), .rbd(rbd),
    .out_data(out_data), .out_valid(out_valid), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] seq(input int l, input int n);
    return 8'((l * 37 + n * 5 + 17) & 255);
  endfunction

  // Scoreboard
  logic [DW-1:0] expq[$];
  bit mon_on = 0, mon_seen = 0, mon_data = 0;
  int mon_first = -1;

  always @(negedge clk) begin
    if (mon_on && rst_n && out_valid) begin
      if (!mon_seen) begin
        mon_seen  = 1;
        mon_first = cyc;
      end
      if (mon_data) begin
        if (expq.size() == 0) chk(0, "R5", "word with empty scoreboard", out_data, 0);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R5", "aligned word (R2 marker first, R6 off lanes zero)", out_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected<%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; in_start = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input logic [LANES-1:0] en, input int sk[LANES], input int rbdv,
                          input int ph, input int n_oct, output int rel_off);
    int s, lmax, e, fire_c, rel;
    int stc[LANES];
    bit xovf;
    logic [DW-1:0] w;
    mon_on = 0;
    expq.delete();
    rbd = RBD_W'(rbdv);
    lane_en = en;
    do_reset();
    // R1 reset state; also shows R7 flag cleared by reset
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err after reset", 32'(ovf_err), 0);
    chk(out_data == '0, "R1", "out_data after reset", out_data, 0);
    while ((cyc % MF) != ph) @(negedge clk);
    s = cyc;
    lmax = -1;
    for (int l = 0; l < LANES; l++) begin
      stc[l] = s + sk[l];
      if (en[l] && stc[l] > lmax) lmax = stc[l];
    end
    e = lmax + 1;
    while ((e % MF) != 0) e++;
    fire_c = e + rbdv;
    xovf = 0;
    for (int l = 0; l < LANES; l++)
      if (en[l] && (fire_c - stc[l]) > DEPTH) xovf = 1;
    mon_seen = 0; mon_first = -1; mon_data = !xovf; mon_on = 1;
    for (int t = 0; t < (lmax - s) + n_oct; t++) begin
      w = '0;
      for (int l = 0; l < LANES; l++) begin
        rel = s + t - stc[l];
        in_valid[l] = 1'b1;
        in_start[l] = (rel == 0);
        in_data[l*OCT_W +: OCT_W] = (rel >= 0) ? seq(l, rel) : 8'hBC;
        if (en[l]) w[l*OCT_W +: OCT_W] = seq(l, s + t - lmax);
      end
      if (s + t >= lmax) expq.push_back(w);
      @(negedge clk);
    end
    in_valid = '0; in_start = '0;
    repeat (3 * MF + DEPTH) @(negedge clk);
    chk(mon_seen && mon_first == fire_c + 1, "R4", "first out_valid cycle", 32'(mon_first), 32'(fire_c + 1));
    if (!xovf) chk(expq.size() == 0, "R5", "scoreboard drained", 32'(expq.size()), 0);
    chk(ovf_err == xovf, "R7", "overflow flag", 32'(ovf_err), 32'(xovf));
    rel_off = mon_first - s;
    mon_on = 0;
  endtask

  initial begin
    int off1, off2, off3, off4, off5, off6;
    rst_n = 1'b0; lane_en = '0; in_valid = '0; in_start = '0; in_data = '0; rbd = '0;
    // Skewed lanes, edge right after last marker
    run_case(4'b1111, '{0, 1, 2, 3}, 2, 4, 20, off1);
    chk(off1 == 7, "R4", "release offset rbd=2", 32'(off1), 7);
    // Edge coincides with the markers: ignored, next edge used, rbd=0
    run_case(4'b1111, '{0, 0, 0, 0}, 0, 0, 16, off2);
    chk(off2 == 9, "R3", "edge in marker cycle skipped", 32'(off2), 9);
    // Lane 2 disabled with a late marker that must not be awaited
    run_case(4'b1011, '{1, 0, 7, 2}, 5, 5, 16, off3);
    chk(off3 == 9, "R6", "disabled lane not awaited", 32'(off3), 9);
    // Largest delay
    run_case(4'b1111, '{3, 3, 3, 3}, 7, 4, 16, off4);
    chk(off4 == 12, "R4", "release offset rbd=7", 32'(off4), 12);
    // Buffering beyond one multiframe: sticky overflow
    run_case(4'b1111, '{0, 1, 2, 3}, 3, 0, 20, off5);
    chk(ovf_err == 1'b1, "R7", "overflow still held", 32'(ovf_err), 1);
    // Restart with the first case's conditions
    run_case(4'b1111, '{0, 1, 2, 3}, 2, 4, 20, off6);
    chk(off6 == off1, "R8", "same latency after restart", 32'(off6), 32'(off1));
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule